// File: doc/BRIEF.md
# PWM Action Qualifier with Software Force

This block turns time-base events into two PWM output levels, A and B. Four event inputs (counter at zero, counter at period, counter equal to compare A while counting up, counter equal to compare B while counting up) are sampled on cycles where the time-base clock enable is high. Each output has its own action word. The word gives every event a 2-bit code: hold, drive low, drive high or toggle. When several events arrive together, a fixed priority decides which code applies.

A software force can hold either output at a fixed level, and while it is active it overrides every event action. Force writes go into a shadow register. The active force is copied from the shadow at the reload point chosen by a 2-bit mode: counter zero, counter period, either of the two, or every time-base clock. The usual setup for an up-counting edge-aligned waveform is period-sets, compare-clears (normal polarity), or the swapped pair for inverted polarity.

Top module: `pwm_action_qual`

## Requirements
- R1: While reset is asserted, both outputs are low.
- R2: Outputs and the active force change only on clock edges where `tbClkEn` is high. Events present on other cycles are ignored.
- R3: Action codes: 2'b00 holds the output, 2'b01 drives it low, 2'b10 drives it high, 2'b11 inverts it.
- R4: Action word field positions: zero event bits 1:0, period event bits 3:2, compare A up bits 5:4, compare B up bits 9:8. All other bits are ignored.
- R5: When more than one event is present, the present event with a non-hold code and the highest priority decides. Priority from high to low is compare B, compare A, period, zero.
- R6: Force field positions: output A uses `forceData` bits 1:0 and output B uses bits 3:2. Force codes: 2'b01 forces low, 2'b10 forces high, and 2'b00 and 2'b11 apply no force.
- R7: An active force on an output overrides all event actions on that output.
- R8: `forceWr` stores `forceData` in the shadow only. The shadow becomes the active force on a `tbClkEn` edge that is a reload point: mode 2'b00 on the zero event, 2'b01 on the period event, 2'b10 on either. On that edge the output already follows the new force.
- R9: With mode 2'b11, a force written on one edge controls the outputs from the next `tbClkEn` edge after it.
- R10: Action word 0x018 on A (period high, compare A low) gives a high level from period to compare A. Action word 0x108 on B does the same with compare B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbClkEn | input | 1 | Time-base clock enable |
| evZero | input | 1 | Counter reached zero |
| evPeriod | input | 1 | Counter reached period |
| evCmpAUp | input | 1 | Counter equals compare A while counting up |
| evCmpBUp | input | 1 | Counter equals compare B while counting up |
| actCtrlA | input | 12 | Action word for output A |
| actCtrlB | input | 12 | Action word for output B |
| forceWr | input | 1 | Write strobe for the force shadow |
| forceData | input | 4 | New force codes (A in 1:0, B in 3:2) |
| reloadMode | input | 2 | Reload point for the force shadow |
| pwmA | output | 1 | PWM output A |
| pwmB | output | 1 | PWM output B |

## Verification
A wrong shadow or active force shows at the ports no later than the first `tbClkEn` edge where that force should win over, or lose to, an event. So the bench compares both outputs against a behavioural model on every clock. If an output register toggles wrongly, the error stays visible until the next event that sets the level, so it is caught at the next sample. Directed phases force each reload mode to wait for, or skip, its reload point. A long random phase mixes events, action words and force writes, which exercises the priority rules.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int NUM_CH = 2;
  localparam int ACT_W = 12;
  localparam int CODE_W = 2;
  localparam int FRC_W = NUM_CH * CODE_W;

  // event field LSBs inside an action word
  localparam int ZERO_LSB = 0;
  localparam int PRD_LSB = 2;
  localparam int CMPA_LSB = 4;
  localparam int CMPB_LSB = 8;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOGGLE = 2'b11
  } actCode_e;

  typedef enum logic [1:0] {
    FRC_OFF = 2'b00,
    FRC_LOW = 2'b01,
    FRC_HIGH = 2'b10,
    FRC_RSVD = 2'b11
  } frcCode_e;

  typedef enum logic [1:0] {
    RLD_ZERO = 2'b00,
    RLD_PRD = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW = 2'b11
  } reload_e;

  typedef struct packed {
    logic step;
    logic [NUM_CH-1:0][CODE_W-1:0] act;
    logic [NUM_CH-1:0][CODE_W-1:0] frc;
  } aqStrobe_t;
endpackage

// File: rtl/pwm_aq_ctrl.sv
module pwm_aq_ctrl
  import pwm_aq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tbClkEn,
  input  logic evZero,
  input  logic evPeriod,
  input  logic evCmpAUp,
  input  logic evCmpBUp,
  input  logic [NUM_CH-1:0][ACT_W-1:0] actWord,
  input  logic forceWr,
  input  logic [FRC_W-1:0] forceData,
  input  logic [1:0] reloadMode,
  output aqStrobe_t strobe
);
  logic [FRC_W-1:0] shadowFrc;
  logic [FRC_W-1:0] activeFrc;
  logic [FRC_W-1:0] effFrc;
  logic loadNow;

  // reload point decision
  always_comb begin
    unique case (reload_e'(reloadMode))
      RLD_ZERO:   loadNow = evZero;
      RLD_PRD:    loadNow = evPeriod;
      RLD_EITHER: loadNow = evZero | evPeriod;
      default:    loadNow = 1'b1;
    endcase
    loadNow = loadNow & tbClkEn;
  end

  assign effFrc = loadNow ? shadowFrc : activeFrc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadowFrc <= '0;
      activeFrc <= '0;
    end else begin
      if (forceWr) shadowFrc <= forceData;
      if (loadNow) activeFrc <= shadowFrc;
    end
  end

  // event resolution: later assignments win, so they carry higher priority
  always_comb begin
    strobe.step = tbClkEn;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      strobe.act[ch] = ACT_NONE;
      if (evZero && actWord[ch][ZERO_LSB +: CODE_W] != ACT_NONE)
        strobe.act[ch] = actWord[ch][ZERO_LSB +: CODE_W];
      if (evPeriod && actWord[ch][PRD_LSB +: CODE_W] != ACT_NONE)
        strobe.act[ch] = actWord[ch][PRD_LSB +: CODE_W];
      if (evCmpAUp && actWord[ch][CMPA_LSB +: CODE_W] != ACT_NONE)
        strobe.act[ch] = actWord[ch][CMPA_LSB +: CODE_W];
      if (evCmpBUp && actWord[ch][CMPB_LSB +: CODE_W] != ACT_NONE)
        strobe.act[ch] = actWord[ch][CMPB_LSB +: CODE_W];
      strobe.frc[ch] = effFrc[ch*CODE_W +: CODE_W];
    end
  end

  // R8
  shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forceWr |=> shadowFrc == $past(forceData));

  // R2
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tbClkEn |=> $stable(activeFrc));
endmodule

// File: rtl/pwm_aq_dp.sv
module pwm_aq_dp
  import pwm_aq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  aqStrobe_t strobe,
  output logic [NUM_CH-1:0] pwmOut
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic lvl;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl <= 1'b0;
      end else if (strobe.step) begin
        if (strobe.frc[ch] == FRC_LOW) lvl <= 1'b0;
        else if (strobe.frc[ch] == FRC_HIGH) lvl <= 1'b1;
        else begin
          unique case (actCode_e'(strobe.act[ch]))
            ACT_LOW:    lvl <= 1'b0;
            ACT_HIGH:   lvl <= 1'b1;
            ACT_TOGGLE: lvl <= ~lvl;
            default:    lvl <= lvl;
          endcase
        end
      end
    end

    assign pwmOut[ch] = lvl;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe.step |=> $stable(pwmOut[ch]));

    // R7
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.step && strobe.frc[ch] == FRC_LOW |=> !pwmOut[ch]);

    // R7
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.step && strobe.frc[ch] == FRC_HIGH |=> pwmOut[ch]);

    // R3
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.step && strobe.act[ch] == ACT_TOGGLE &&
      (strobe.frc[ch] == FRC_OFF || strobe.frc[ch] == FRC_RSVD)
      |=> pwmOut[ch] != $past(pwmOut[ch]));
  end
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tbClkEn,
  input  logic evZero,
  input  logic evPeriod,
  input  logic evCmpAUp,
  input  logic evCmpBUp,
  input  logic [11:0] actCtrlA,
  input  logic [11:0] actCtrlB,
  input  logic forceWr,
  input  logic [3:0] forceData,
  input  logic [1:0] reloadMode,
  output logic pwmA,
  output logic pwmB
);
  logic [NUM_CH-1:0][ACT_W-1:0] actWord;
  logic [NUM_CH-1:0] pwmOut;
  aqStrobe_t strobe;

  assign actWord[0] = actCtrlA;
  assign actWord[1] = actCtrlB;

  pwm_aq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tbClkEn(tbClkEn),
    .evZero(evZero), .evPeriod(evPeriod),
    .evCmpAUp(evCmpAUp), .evCmpBUp(evCmpBUp),
    .actWord(actWord), .forceWr(forceWr), .forceData(forceData),
    .reloadMode(reloadMode), .strobe(strobe)
  );

  pwm_aq_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pwmOut(pwmOut)
  );

  assign pwmA = pwmOut[0];
  assign pwmB = pwmOut[1];

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> !pwmA && !pwmB);
endmodule

// File: tb/sim_pwm_action_qual.sv
module sim_pwm_action_qual;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbClkEn = 0, evZero = 0, evPeriod = 0, evCmpAUp = 0, evCmpBUp = 0;
  logic [11:0] actCtrlA = '0, actCtrlB = '0;
  logic forceWr = 0;
  logic [3:0] forceData = '0;
  logic [1:0] reloadMode = '0;
  logic pwmA, pwmB;

  always #10 clk = ~clk;

  pwm_action_qual u0 (
    .clk(clk), .rst_n(rst_n), .tbClkEn(tbClkEn),
    .evZero(evZero), .evPeriod(evPeriod),
    .evCmpAUp(evCmpAUp), .evCmpBUp(evCmpBUp),
    .actCtrlA(actCtrlA), .actCtrlB(actCtrlB),
    .forceWr(forceWr), .forceData(forceData),
    .reloadMode(reloadMode), .pwmA(pwmA), .pwmB(pwmB)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural reference state
  int refShadow = 0, refActive = 0;
  bit refOut[2] = '{0, 0};
  string why[2] = '{"R1", "R1"};
  string phaseTag = "";

  // pending stimulus for the next cycle
  logic [11:0] nActA = '0, nActB = '0;
  logic [1:0] nMode = '0;

  task automatic check(string tag, bit act, bit exp, string name);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, name, act, exp, $time);
    end
  endtask

  function automatic void modelStep();
    int fieldLsb[4] = '{8, 4, 2, 0};
    bit present[4];
    bit load;
    int oldShadow = refShadow;
    present = '{evCmpBUp, evCmpAUp, evPeriod, evZero};
    load = 0;
    if (tbClkEn) begin
      case (reloadMode)
        2'd0: load = evZero;
        2'd1: load = evPeriod;
        2'd2: load = evZero | evPeriod;
        default: load = 1;
      endcase
    end
    for (int ch = 0; ch < 2; ch++) begin
      int word = (ch == 0) ? int'(actCtrlA) : int'(actCtrlB);
      int eff = load ? ((oldShadow >> (2*ch)) & 3) : ((refActive >> (2*ch)) & 3);
      int nPresent = 0;
      int code = 0;
      int winner = -1;
      if (!tbClkEn) begin
        why[ch] = "R2";
        continue;
      end
      if (eff == 1 || eff == 2) begin
        refOut[ch] = (eff == 2);
        why[ch] = !load ? "R7" : (reloadMode == 2'd3 ? "R9" : "R8");
      end else begin
        for (int k = 0; k < 4; k++) begin
          if (present[k]) begin
            nPresent++;
            if (winner < 0 && ((word >> fieldLsb[k]) & 3) != 0) begin
              winner = k;
              code = (word >> fieldLsb[k]) & 3;
            end
          end
        end
        if (code == 1) refOut[ch] = 0;
        else if (code == 2) refOut[ch] = 1;
        else if (code == 3) refOut[ch] = !refOut[ch];
        if (eff == 3) why[ch] = "R6";
        else if (nPresent > 1) why[ch] = "R5";
        else if (winner == 0) why[ch] = "R4";
        else if (nPresent == 1) why[ch] = "R3";
        else why[ch] = "R2";
      end
      if (phaseTag != "") why[ch] = phaseTag;
    end
    if (load) refActive = oldShadow;
    if (forceWr) refShadow = int'(forceData);
  endfunction

  task automatic cyc(bit en, bit z, bit p, bit ca, bit cb, bit fw, logic [3:0] fd);
    @(negedge clk);
    check(why[0], pwmA, refOut[0], "pwmA");
    check(why[1], pwmB, refOut[1], "pwmB");
    tbClkEn = en; evZero = z; evPeriod = p; evCmpAUp = ca; evCmpBUp = cb;
    forceWr = fw; forceData = fd;
    actCtrlA = nActA; actCtrlB = nActB; reloadMode = nMode;
    modelStep();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with events and force writes held off
    repeat (3) begin
      @(negedge clk);
      check("R1", pwmA, 1'b0, "pwmA");
      check("R1", pwmB, 1'b0, "pwmB");
    end
    rst_n = 1'b1;

    // R10: normal-polarity waveform from an up counter, period 9
    phaseTag = "R10";
    nActA = 12'h018; nActB = 12'h108; nMode = 2'd3;
    begin
      int cnt = 0;
      for (int i = 0; i < 80; i++) begin
        bit en = (i % 2 == 1);
        cyc(en, en && cnt == 0, en && cnt == 9, en && cnt == 3, en && cnt == 6, 0, 4'h0);
        if (en) cnt = (cnt == 9) ? 0 : cnt + 1;
      end
    end

    // R8: mode zero waits for zero; period-only edges do not load
    phaseTag = "R8";
    nActA = 12'h018; nActB = 12'h108; nMode = 2'd0;
    cyc(0, 0, 0, 0, 0, 1, 4'b0110);
    cyc(1, 0, 1, 0, 0, 0, 4'h0);
    cyc(1, 0, 0, 1, 1, 0, 4'h0);
    cyc(1, 1, 0, 0, 0, 0, 4'h0);
    cyc(1, 0, 1, 1, 1, 0, 4'h0);
    // mode period, then mode either
    nMode = 2'd1;
    cyc(0, 0, 0, 0, 0, 1, 4'b1001);
    cyc(1, 1, 0, 0, 0, 0, 4'h0);
    cyc(1, 0, 1, 0, 0, 0, 4'h0);
    cyc(1, 1, 0, 1, 1, 0, 4'h0);
    nMode = 2'd2;
    cyc(0, 0, 0, 0, 0, 1, 4'b0000);
    cyc(1, 0, 0, 1, 1, 0, 4'h0);
    cyc(1, 1, 0, 0, 0, 0, 4'h0);
    cyc(1, 0, 1, 0, 0, 0, 4'h0);

    // R9: immediate mode, write coincident with an enable edge
    phaseTag = "R9";
    nMode = 2'd3;
    cyc(1, 0, 0, 0, 0, 1, 4'b1010);
    cyc(0, 0, 0, 0, 0, 0, 4'h0);
    cyc(1, 0, 0, 0, 0, 0, 4'h0);
    cyc(1, 1, 1, 1, 1, 1, 4'b0101);
    cyc(1, 0, 0, 0, 0, 0, 4'h0);

    // R6: reserved force code behaves as no force
    phaseTag = "R6";
    nActA = 12'h00C; nActB = 12'h30C;
    cyc(1, 0, 0, 0, 0, 1, 4'b1111);
    cyc(1, 0, 0, 0, 0, 0, 4'h0);
    cyc(1, 0, 1, 0, 0, 0, 4'h0);
    cyc(1, 0, 0, 0, 1, 0, 4'h0);
    cyc(1, 0, 0, 0, 0, 1, 4'b0000);
    cyc(1, 0, 0, 0, 0, 0, 4'h0);

    // random mix covering R2 R3 R4 R5 R7 R8 R9
    phaseTag = "";
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r = $urandom;
      if (i % 64 == 0) begin
        nActA = 12'($urandom);
        nActB = 12'($urandom);
        nMode = 2'($urandom);
      end
      cyc(r[0] | r[1], r[2] & r[3], r[4] & r[5], r[6] & r[7], r[8] & r[9],
          (r[15:10] == 0), r[19:16]);
    end
    cyc(0, 0, 0, 0, 0, 0, 4'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule